// File: doc/BRIEF.md
# Field-Programmable Sum-of-Products Array with Output Inversion

This block is a small programmable AND-OR array. Every input reaches an AND plane as two literals, its true value and its inverse. Each product-term gate can take any subset of those literals. An OR plane then lets any product term drive any output, so one term can serve several outputs. Each output ends in an XOR stage that is set to pass the OR result unchanged or to invert it. This lets a designer build whichever of a function or its complement needs fewer product terms.

The whole configuration is one word of `CFG_W` bits. It is shifted in one bit per clock on `cfg_din` while `cfg_en` is high. After the load, the array evaluates the inputs through combinational logic, and a single output register sits in front of the output port.

Top module: `sop_array`

## Requirements
- R1: A synchronous active-high reset clears the configuration word and the output register. After reset, both outputs read 0 for every input value.
- R2: The configuration word has width CFG_W = N_TERMS*2*N_IN + N_TERMS*N_OUT + N_OUT and is shifted in most significant bit first, one bit per rising edge while `cfg_en` is high.
  - The AND-plane field occupies the top N_TERMS*2*N_IN bits.
  - Below it sits the OR-plane field, N_TERMS*N_OUT bits.
  - The polarity bits occupy bits [N_OUT-1:0].
- R3: In the AND-plane field, term t selects literal j at bit AND_BASE + t*2*N_IN + j, where AND_BASE = N_TERMS*N_OUT + N_OUT.
  - j = 2*i selects input i in true form.
  - j = 2*i+1 selects input i in complemented form.
  - A term is the AND of its selected literals.
- R4: A product term with no literal selected evaluates to 0, so it never asserts an output it is linked to.
- R5: OR-plane bit N_OUT + o*N_TERMS + t links term t to output o. A single term may be linked to several outputs at once.
- R6: Polarity bit o set to 1 inverts output o after its OR gate. A value of 0 passes the OR result through unchanged.
- R7: Outputs are registered. The value on `y_out` after a rising edge reflects `x_in` sampled at that edge, and a change of `x_in` between edges does not show on `y_out` until the next edge.
- R8: After any rising edge at which `cfg_en` is high, `y_out` is 0.
- R9: While `cfg_en` is low, the configuration is held. Activity on `cfg_din` has no effect on the function evaluated.
- R10: With inputs A=x_in[2], B=x_in[1], C=x_in[0] (minterm index = x_in), a configuration of F1 = AB' + AC + A'BC' and F2 = inverse of (AC + BC) gives:
  - F1 minterms {2,4,5,7}
  - F2 minterms {0,1,2,4,6}
  - The AC term is shared between the two outputs.
- R11: With the same input mapping, a configuration of F1 = inverse of (AB + AC + BC) and F2 = AB + AC + A'B'C' gives:
  - F1 minterms {0,1,2,4}
  - F2 minterms {0,5,6,7}

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | N_IN | Logic inputs to the array |
| cfg_din | input | 1 | Serial configuration bit |
| cfg_en | input | 1 | Configuration shift enable |
| y_out | output | N_OUT | Registered array outputs, bit 0 = F1, bit 1 = F2 |

## Verification
A configuration shift and an evaluation of the array can fall on the same rising edge. The bench provokes this by reloading the array while `x_in` is held at a value that drives an output to 1 under the previous configuration. During every shift cycle it checks that `y_out` stays 0. Once the enable drops, it confirms that the next evaluation uses the complete new word, which rules out any partially shifted intermediate configuration.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // Position of a literal inside one term's selection field
  function automatic int lit_pos(input int inp, input bit inverted);
    return 2 * inp + (inverted ? 1 : 0);
  endfunction
endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int W = 50
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] cfg
);
  always_ff @(posedge clk) begin
    if (rst)     cfg <= '0;
    else if (en) cfg <= {cfg[W-2:0], din};
  end

  // R2: new bit enters at the bottom of the chain on each enabled edge
  a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
    en |=> cfg[0] == $past(din));

  // R9: no enable, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cfg));
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_IN    = 3,
  parameter int N_TERMS = 6
) (
  input  logic [N_IN-1:0]           x,
  input  logic [N_TERMS*2*N_IN-1:0] sel,
  output logic [N_TERMS-1:0]        terms
);
  import sop_pkg::*;
  localparam int LW = 2 * N_IN;

  logic [LW-1:0] lits;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[lit_pos(i, 1'b0)] = x[i];
    assign lits[lit_pos(i, 1'b1)] = ~x[i];
  end

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [LW-1:0] tsel;
    assign tsel = sel[t*LW +: LW];
    // An empty selection yields 0 rather than the AND identity
    assign terms[t] = (|tsel) & (&(~tsel | lits));
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_TERMS = 6,
  parameter int N_OUT   = 2
) (
  input  logic [N_TERMS-1:0]       terms,
  input  logic [N_TERMS*N_OUT-1:0] links,
  input  logic [N_OUT-1:0]         pol,
  output logic [N_OUT-1:0]         f
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic sum;
    assign sum  = |(terms & links[o*N_TERMS +: N_TERMS]);
    assign f[o] = sum ^ pol[o];
  end
endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN    = 3,
  parameter int N_TERMS = 6,
  parameter int N_OUT   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  x_in,
  input  logic             cfg_din,
  input  logic             cfg_en,
  output logic [N_OUT-1:0] y_out
);
  localparam int AW      = N_TERMS * 2 * N_IN;
  localparam int OW      = N_TERMS * N_OUT;
  localparam int CFG_W   = AW + OW + N_OUT;
  localparam int OR_BASE = N_OUT;
  localparam int AND_BASE = N_OUT + OW;

  logic [CFG_W-1:0]   cfg;
  logic [N_TERMS-1:0] terms;
  logic [N_OUT-1:0]   f;
  logic               rst_d;

  sop_cfg_chain #(.W(CFG_W)) u_chain (
    .clk (clk),
    .rst (rst),
    .en  (cfg_en),
    .din (cfg_din),
    .cfg (cfg)
  );

  sop_and_plane #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_and (
    .x     (x_in),
    .sel   (cfg[AND_BASE +: AW]),
    .terms (terms)
  );

  sop_or_plane #(.N_TERMS(N_TERMS), .N_OUT(N_OUT)) u_or (
    .terms (terms),
    .links (cfg[OR_BASE +: OW]),
    .pol   (cfg[N_OUT-1:0]),
    .f     (f)
  );

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst || cfg_en) y_out <= '0;
    else               y_out <= f;
  end

  // R8: a shift cycle leaves the outputs low
  a_r8_quiet_load: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> y_out == '0);

  // R1: first cycle out of reset sees cleared state
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (y_out == '0 && cfg == '0));
endmodule

// File: tb/sop_array_test.sv
module sop_array_test;
  localparam int N_IN = 3, N_TERMS = 6, N_OUT = 2;
  localparam int LW = 2 * N_IN;
  localparam int OW = N_TERMS * N_OUT;
  localparam int W  = N_TERMS * LW + OW + N_OUT;
  localparam int AND_BASE = OW + N_OUT;

  logic clk = 1'b0, rst = 1'b1, cfg_din = 1'b0, cfg_en = 1'b0;
  logic [N_IN-1:0]  x_in = '0;
  logic [N_OUT-1:0] y_out;
  int checks = 0, errors = 0;
  bit quiet_watch = 1'b0;

  sop_array #(.N_IN(N_IN), .N_TERMS(N_TERMS), .N_OUT(N_OUT)) uut (
    .clk(clk), .rst(rst), .x_in(x_in), .cfg_din(cfg_din),
    .cfg_en(cfg_en), .y_out(y_out)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [N_OUT-1:0] got, input logic [N_OUT-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] lit(input logic [W-1:0] w, input int t, input int i, input bit inv);
    w[AND_BASE + t*LW + 2*i + (inv ? 1 : 0)] = 1'b1;
    return w;
  endfunction

  function automatic logic [W-1:0] lnk(input logic [W-1:0] w, input int t, input int o);
    w[N_OUT + o*N_TERMS + t] = 1'b1;
    return w;
  endfunction

  task automatic load(input logic [W-1:0] w, input bit watch);
    for (int k = W - 1; k >= 0; k--) begin
      @(negedge clk);
      if (watch && k < W - 1) chk("R8 output low while shifting", y_out, '0);
      cfg_en = 1'b1; cfg_din = w[k];
    end
    @(negedge clk);
    if (watch) chk("R8 output low on last shift", y_out, '0);
    cfg_en = 1'b0; cfg_din = 1'b0;
  endtask

  task automatic table_check(input string req, input logic [7:0] m1, input logic [7:0] m2);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk); x_in = v[N_IN-1:0];
      @(negedge clk); chk(req, y_out, {m2[v], m1[v]});
    end
  endtask

  // A=x[2], B=x[1], C=x[0]
  function automatic logic [W-1:0] cfg_one();
    logic [W-1:0] w = '0;
    w = lit(w, 0, 2, 0); w = lit(w, 0, 1, 1);                     // AB'
    w = lit(w, 1, 2, 0); w = lit(w, 1, 0, 0);                     // AC
    w = lit(w, 2, 2, 1); w = lit(w, 2, 1, 0); w = lit(w, 2, 0, 1); // A'BC'
    w = lit(w, 3, 1, 0); w = lit(w, 3, 0, 0);                     // BC
    w = lnk(w, 0, 0); w = lnk(w, 1, 0); w = lnk(w, 2, 0);
    w = lnk(w, 4, 0);                  // R4: empty term 4 linked to F1
    w = lnk(w, 1, 1); w = lnk(w, 3, 1); // shared AC
    w[1] = 1'b1;                        // invert F2
    return w;
  endfunction

  function automatic logic [W-1:0] cfg_two();
    logic [W-1:0] w = '0;
    w = lit(w, 0, 2, 0); w = lit(w, 0, 1, 0);                     // AB
    w = lit(w, 1, 2, 0); w = lit(w, 1, 0, 0);                     // AC
    w = lit(w, 2, 1, 0); w = lit(w, 2, 0, 0);                     // BC
    w = lit(w, 3, 2, 1); w = lit(w, 3, 1, 1); w = lit(w, 3, 0, 1); // A'B'C'
    w = lnk(w, 0, 0); w = lnk(w, 1, 0); w = lnk(w, 2, 0);
    w = lnk(w, 0, 1); w = lnk(w, 1, 1); w = lnk(w, 3, 1);
    w[0] = 1'b1;                        // invert F1
    return w;
  endfunction

  task automatic t_reset_state();
    table_check("R1 reset state", 8'h00, 8'h00);
  endtask

  task automatic t_ref_one();
    load(cfg_one(), 1'b0);
    table_check("R10 R3 R4 R5 R6 ref one", 8'hB4, 8'h57);
  endtask

  task automatic t_hold();
    @(negedge clk); cfg_en = 1'b0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk); cfg_din = k[0] ^ k[2];
    end
    cfg_din = 1'b0;
    table_check("R9 config held", 8'hB4, 8'h57);
  endtask

  task automatic t_reload_quiet();
    @(negedge clk); x_in = 3'd2;
    @(negedge clk); chk("R8 pre-load value", y_out, 2'b11);
    load(cfg_two(), 1'b1);
    @(negedge clk); chk("R2 R8 first eval after load", y_out, 2'b01);
    table_check("R11 R2 R6 ref two", 8'h17, 8'hE1);
  endtask

  task automatic t_latency();
    @(negedge clk); x_in = 3'd0;
    @(posedge clk); #1 chk("R7 sampled at edge", y_out, 2'b11);
    x_in = 3'd6;
    #1 chk("R7 no change between edges", y_out, 2'b11);
    @(posedge clk); #1 chk("R7 next edge", y_out, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_ref_one();
    t_hold();
    t_reload_quiet();
    t_latency();
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule